// File: doc/BRIEF.md
# Aligned significand subtractor with normalization

The block computes the magnitude difference of two normalized 64-bit unsigned significands, each carrying a 16-bit two's-complement exponent. The first operand must be the larger one. The smaller significand is shifted right by the exponent difference into a 96-bit working value: 64 significand bits followed by a 32-bit guard word. The guard word keeps the bits that were shifted out, and its least significant bit serves as a sticky bit for shifts that drop more than it can hold. The aligned value is subtracted from the larger operand, which is extended with a zero guard word. The difference is then shifted left until its top bit is set, and the exponent is reduced to match.

The result is the normalized significand, the guard word (for a later rounding stage), the exponent, and flags for zero, exponent underflow and internal error. Sign handling and rounding are left to neighbouring logic. One operation enters per valid/ready handshake, and each result is held in a single output register until it is taken.

Top module: `sigdiff_norm`

## Requirements
- R1: `in_ready` is high exactly when the output register is empty or is taken in the same cycle. An operation accepted at a clock edge appears on the outputs with `out_valid` high after that edge. All result outputs hold steady while `out_valid` is high and `out_ready` is low.
- R2: If bit 63 of either significand is clear, or if `a_exp` is less than `b_exp` as signed values, the result has `res_err`=1, with significand, guard and exponent all zero and `res_zero`=`res_uflow`=0.
- R3: For an exponent difference of 0 to 31, the 96-bit value {b_sig, 32'h0} is shifted right exactly, with no bit lost. For a difference of exactly 32, the significand becomes {32'h0, b_sig[63:32]} and the guard word becomes b_sig[31:0], with no sticky bit.
- R4: For a difference d of 33 to 64, only b_sig[63:32] feeds the aligned value: the aligned significand is b_sig[63:32] >> (d-32), and the guard word holds the bits of b_sig[63:32] shifted out of it. The guard LSB is then ORed with (b_sig[31:0] != 0).
- R5: For a difference of 65, the aligned significand is zero and the guard word is b_sig[63:33]. Its LSB is set if b_sig[32] is 1 or if b_sig[31:0] is nonzero.
- R6: For a difference of 66 or more, the aligned significand is zero and the guard word is exactly 32'h1.
- R7: The 96-bit subtraction {a_sig, 32'h0} minus the aligned value must not borrow out of the top. If it does, the result is an error as in R2.
- R8: A nonzero difference leaves the block with bit 63 of `res_sig` set. `res_exp` equals `a_exp` minus the left shift applied to the whole 96-bit difference, and `res_ext` holds the low 32 bits after that shift.
- R9: A difference whose only set bit is guard bit 31 yields `res_sig`=64'h8000_0000_0000_0000, `res_ext`=0 and `res_exp`=`a_exp`-64.
- R10: A zero difference yields `res_zero`=1 with significand, guard and exponent all zero.
- R11: If the true exponent a_exp minus the shift is below -32768, `res_uflow`=1 and `res_exp` carries the low 16 bits of the true value. Otherwise `res_uflow`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| a_sig | input | 64 | Larger significand |
| a_exp | input | 16 | Exponent of the larger operand, two's complement |
| b_sig | input | 64 | Smaller significand |
| b_exp | input | 16 | Exponent of the smaller operand, two's complement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| res_sig | output | 64 | Normalized difference significand |
| res_ext | output | 32 | Guard word with sticky LSB |
| res_exp | output | 16 | Result exponent |
| res_zero | output | 1 | Difference is zero |
| res_uflow | output | 1 | Exponent fell below its range |
| res_err | output | 1 | Invalid operands or impossible borrow |

## Verification
On every cycle, the assertions check the handshake rules and that a held result stays stable. They also check that a nonzero result is normalized, that a zero result is all zeros, that the error and zero flags never appear together, and that an operand with bit 63 clear produces an error. Whether the guard word and sticky bit match each of the alignment ranges, including the exact borders at 31, 32, 33, 63, 64, 65 and 66, can only be shown by the bench scenarios, which compare complete results against a model of the requirements. The same applies to the shift-by-64 near-cancellation, the exponent wrap that sets underflow, and the borrow-out error.

// File: rtl/sigdiff_norm_pkg.sv
package sigdiff_norm_pkg;

    localparam int DEF_WORD_W = 32;
    localparam int DEF_EXP_W  = 16;

    typedef enum logic [2:0] {
        ALN_NEAR,      // shift below one word
        ALN_WORD,      // shift of exactly one word
        ALN_MID,       // shift up to two words, low word becomes sticky
        ALN_ONE_PAST,  // shift one beyond two words
        ALN_FAR        // everything collapses into the sticky bit
    } align_case_e;

endpackage

// File: rtl/sigdiff_align.sv
module sigdiff_align
    import sigdiff_norm_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    localparam int SIG_W = 2 * WORD_W,
    localparam int CLAMP = 2 * WORD_W + 2,
    localparam int SHW   = $clog2(CLAMP + 1)
) (
    input  logic [SIG_W-1:0]  b_sig,
    input  logic [SHW-1:0]    shamt,
    output logic [SIG_W-1:0]  al_sig,
    output logic [WORD_W-1:0] al_ext
);

    logic [WORD_W-1:0]   hi_w;
    logic [WORD_W-1:0]   lo_w;
    logic                lo_any;
    logic [SHW-1:0]      part_sh;
    logic [SIG_W-1:0]    hi_shift;
    logic [SIG_W+WORD_W-1:0] near_v;
    align_case_e         sel;

    assign hi_w   = b_sig[SIG_W-1:WORD_W];
    assign lo_w   = b_sig[WORD_W-1:0];
    assign lo_any = |lo_w;

    always_comb begin
        if (shamt < SHW'(WORD_W))
            sel = ALN_NEAR;
        else if (shamt == SHW'(WORD_W))
            sel = ALN_WORD;
        else if (shamt <= SHW'(2 * WORD_W))
            sel = ALN_MID;
        else if (shamt == SHW'(2 * WORD_W + 1))
            sel = ALN_ONE_PAST;
        else
            sel = ALN_FAR;
    end

    always_comb begin
        part_sh  = shamt - SHW'(WORD_W);
        hi_shift = {hi_w, {WORD_W{1'b0}}} >> part_sh;
        near_v   = {b_sig, {WORD_W{1'b0}}} >> shamt;
        al_sig   = '0;
        al_ext   = '0;
        unique case (sel)
            ALN_NEAR: begin
                al_sig = near_v[SIG_W+WORD_W-1:WORD_W];
                al_ext = near_v[WORD_W-1:0];
            end
            ALN_WORD: begin
                al_sig = {{WORD_W{1'b0}}, hi_w};
                al_ext = lo_w;
            end
            ALN_MID: begin
                al_sig = {{WORD_W{1'b0}}, hi_shift[SIG_W-1:WORD_W]};
                al_ext = hi_shift[WORD_W-1:0] | {{(WORD_W-1){1'b0}}, lo_any};
            end
            ALN_ONE_PAST: begin
                al_sig = '0;
                al_ext = {1'b0, hi_w[WORD_W-1:1]}
                       | {{(WORD_W-1){1'b0}}, hi_w[0] | lo_any};
            end
            default: begin
                al_sig = '0;
                al_ext = {{(WORD_W-1){1'b0}}, 1'b1};
            end
        endcase
    end

endmodule

// File: rtl/sigdiff_lnorm.sv
module sigdiff_lnorm
    import sigdiff_norm_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    localparam int SIG_W = 2 * WORD_W,
    localparam int ALL_W = 3 * WORD_W,
    localparam int CLAMP = 2 * WORD_W + 2,
    localparam int SHW   = $clog2(CLAMP + 1),
    localparam int LZW   = $clog2(WORD_W)
) (
    input  logic [ALL_W-1:0]  diff,
    output logic [SIG_W-1:0]  n_sig,
    output logic [WORD_W-1:0] n_ext,
    output logic [SHW-1:0]    n_dec,
    output logic              n_zero,
    output logic              n_bad
);

    function automatic logic [LZW-1:0] lead_zeros(input logic [WORD_W-1:0] w);
        logic [LZW-1:0] cnt;
        logic           seen;
        cnt  = '0;
        seen = 1'b0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (!seen && !w[i])
                cnt = cnt + 1'b1;
            else
                seen = 1'b1;
        end
        return cnt;
    endfunction

    logic [WORD_W-1:0] top_w;
    logic [WORD_W-1:0] mid_w;
    logic [WORD_W-1:0] grd_w;
    logic [ALL_W-1:0]  moved;
    logic [ALL_W-1:0]  shifted;
    logic [LZW-1:0]    lz;

    assign top_w = diff[ALL_W-1:SIG_W];
    assign mid_w = diff[SIG_W-1:WORD_W];
    assign grd_w = diff[WORD_W-1:0];

    always_comb begin
        moved   = diff;
        lz      = '0;
        shifted = diff;
        n_dec   = '0;
        n_zero  = 1'b0;
        n_bad   = 1'b0;
        if (top_w[WORD_W-1]) begin
            shifted = diff;
        end else if (top_w != '0) begin
            lz      = lead_zeros(top_w);
            shifted = diff << lz;
            n_dec   = SHW'(lz);
        end else if (mid_w != '0) begin
            moved   = {mid_w, grd_w, {WORD_W{1'b0}}};
            lz      = lead_zeros(mid_w);
            shifted = moved << lz;
            n_dec   = SHW'(WORD_W) + SHW'(lz);
        end else if (grd_w == {1'b1, {(WORD_W-1){1'b0}}}) begin
            shifted = {grd_w, {SIG_W{1'b0}}};
            n_dec   = SHW'(SIG_W);
        end else if (grd_w == '0) begin
            shifted = '0;
            n_zero  = 1'b1;
        end else begin
            shifted = '0;
            n_bad   = 1'b1;
        end
        n_sig = shifted[ALL_W-1:WORD_W];
        n_ext = shifted[WORD_W-1:0];
    end

endmodule

// File: rtl/sigdiff_norm.sv
module sigdiff_norm
    import sigdiff_norm_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int EXP_W  = DEF_EXP_W,
    localparam int SIG_W = 2 * WORD_W,
    localparam int ALL_W = 3 * WORD_W,
    localparam int CLAMP = 2 * WORD_W + 2,
    localparam int SHW   = $clog2(CLAMP + 1),
    localparam int XW    = EXP_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SIG_W-1:0]  a_sig,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [SIG_W-1:0]  b_sig,
    input  logic [EXP_W-1:0]  b_exp,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SIG_W-1:0]  res_sig,
    output logic [WORD_W-1:0] res_ext,
    output logic [EXP_W-1:0]  res_exp,
    output logic              res_zero,
    output logic              res_uflow,
    output logic              res_err
);

    typedef struct packed {
        logic              valid;
        logic [SIG_W-1:0]  sig;
        logic [WORD_W-1:0] ext;
        logic [EXP_W-1:0]  exp;
        logic              zero;
        logic              uflow;
        logic              err;
    } result_t;

    localparam logic signed [XW-1:0] EXP_MIN = XW'(-(2 ** (EXP_W - 1)));

    result_t r_d, r_q;

    logic signed [XW-1:0] exp_gap;
    logic signed [XW-1:0] exp_full;
    logic [SHW-1:0]       shamt;
    logic                 bad_in;
    logic [SIG_W-1:0]     al_sig;
    logic [WORD_W-1:0]    al_ext;
    logic [ALL_W:0]       sub_full;
    logic [SIG_W-1:0]     n_sig;
    logic [WORD_W-1:0]    n_ext;
    logic [SHW-1:0]       n_dec;
    logic                 n_zero;
    logic                 n_bad;
    logic                 take;

    always_comb begin
        exp_gap = $signed({{2{a_exp[EXP_W-1]}}, a_exp})
                - $signed({{2{b_exp[EXP_W-1]}}, b_exp});
        bad_in  = !a_sig[SIG_W-1] || !b_sig[SIG_W-1] || exp_gap[XW-1];
        if (exp_gap[XW-1])
            shamt = '0;
        else if (exp_gap >= XW'(CLAMP))
            shamt = SHW'(CLAMP);
        else
            shamt = exp_gap[SHW-1:0];
    end

    sigdiff_align #(.WORD_W(WORD_W)) u_align (
        .b_sig  (b_sig),
        .shamt  (shamt),
        .al_sig (al_sig),
        .al_ext (al_ext)
    );

    assign sub_full = {1'b0, a_sig, {WORD_W{1'b0}}} - {1'b0, al_sig, al_ext};

    sigdiff_lnorm #(.WORD_W(WORD_W)) u_lnorm (
        .diff   (sub_full[ALL_W-1:0]),
        .n_sig  (n_sig),
        .n_ext  (n_ext),
        .n_dec  (n_dec),
        .n_zero (n_zero),
        .n_bad  (n_bad)
    );

    assign in_ready = !r_q.valid || out_ready;
    assign take     = in_valid && in_ready;

    always_comb begin
        r_d      = r_q;
        exp_full = $signed({{2{a_exp[EXP_W-1]}}, a_exp})
                 - $signed({{(XW-SHW){1'b0}}, n_dec});
        if (out_ready)
            r_d.valid = 1'b0;
        if (take) begin
            r_d.valid = 1'b1;
            if (bad_in || sub_full[ALL_W] || n_bad) begin
                r_d.sig   = '0;
                r_d.ext   = '0;
                r_d.exp   = '0;
                r_d.zero  = 1'b0;
                r_d.uflow = 1'b0;
                r_d.err   = 1'b1;
            end else if (n_zero) begin
                r_d.sig   = '0;
                r_d.ext   = '0;
                r_d.exp   = '0;
                r_d.zero  = 1'b1;
                r_d.uflow = 1'b0;
                r_d.err   = 1'b0;
            end else begin
                r_d.sig   = n_sig;
                r_d.ext   = n_ext;
                r_d.exp   = exp_full[EXP_W-1:0];
                r_d.zero  = 1'b0;
                r_d.uflow = exp_full < EXP_MIN;
                r_d.err   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign out_valid = r_q.valid;
    assign res_sig   = r_q.sig;
    assign res_ext   = r_q.ext;
    assign res_exp   = r_q.exp;
    assign res_zero  = r_q.zero;
    assign res_uflow = r_q.uflow;
    assign res_err   = r_q.err;

endmodule

// File: rtl/sigdiff_norm_chk.sv
module sigdiff_norm_chk #(
    parameter int SIG_W  = 64,
    parameter int WORD_W = 32,
    parameter int EXP_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              a_msb,
    input logic              b_msb,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SIG_W-1:0]  res_sig,
    input logic [WORD_W-1:0] res_ext,
    input logic [EXP_W-1:0]  res_exp,
    input logic              res_zero,
    input logic              res_uflow,
    input logic              res_err
);

    // R1
    blocked_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R1
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(res_sig) && $stable(res_ext)
            && $stable(res_exp) && $stable(res_zero) && $stable(res_uflow) && $stable(res_err)));

    // R1
    accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R2
    bad_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (!a_msb || !b_msb)) |=> (res_err && res_sig == '0));

    // R8
    normalized_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !res_zero && !res_err) |-> res_sig[SIG_W-1]);

    // R10
    zero_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_zero) |-> (res_sig == '0 && res_ext == '0 && res_exp == '0 && !res_uflow));

    // R2
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(res_zero && res_err));

endmodule

bind sigdiff_norm sigdiff_norm_chk #(
    .SIG_W  (2 * WORD_W),
    .WORD_W (WORD_W),
    .EXP_W  (EXP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .a_msb     (a_sig[2*WORD_W-1]),
    .b_msb     (b_sig[2*WORD_W-1]),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .res_sig   (res_sig),
    .res_ext   (res_ext),
    .res_exp   (res_exp),
    .res_zero  (res_zero),
    .res_uflow (res_uflow),
    .res_err   (res_err)
);

// File: tb/sigdiff_norm_tb.sv
module sigdiff_norm_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] a_sig = '0;
    logic [15:0] a_exp = '0;
    logic [63:0] b_sig = '0;
    logic [15:0] b_exp = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] res_sig;
    logic [31:0] res_ext;
    logic [15:0] res_exp;
    logic        res_zero;
    logic        res_uflow;
    logic        res_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sigdiff_norm u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .a_sig(a_sig), .a_exp(a_exp), .b_sig(b_sig), .b_exp(b_exp),
        .out_valid(out_valid), .out_ready(out_ready),
        .res_sig(res_sig), .res_ext(res_ext), .res_exp(res_exp),
        .res_zero(res_zero), .res_uflow(res_uflow), .res_err(res_err)
    );

    // Expected result packed as {sig, ext, exp, zero, uflow, err}
    function automatic logic [114:0] model(input logic [63:0] a, input logic [15:0] ae,
                                           input logic [63:0] b, input logic [15:0] be);
        int          d;
        int          k;
        int          n;
        int          ex;
        logic [63:0] bs;
        logic [31:0] bx;
        logic [63:0] tmp;
        logic [96:0] df;
        logic [95:0] v;
        d = int'($signed(ae)) - int'($signed(be));
        if (!a[63] || !b[63] || d < 0)
            return {64'h0, 32'h0, 16'h0, 1'b0, 1'b0, 1'b1};
        if (d <= 32) begin
            {bs, bx} = {b, 32'h0} >> d;
        end else if (d <= 64) begin
            k   = d - 32;
            tmp = {b[63:32], 32'h0} >> k;
            bs  = {32'h0, tmp[63:32]};
            bx  = tmp[31:0] | {31'h0, b[31:0] != 0};
        end else if (d == 65) begin
            bs = '0;
            bx = {1'b0, b[63:33]} | {31'h0, b[32] | (b[31:0] != 0)};
        end else begin
            bs = '0;
            bx = 32'h1;
        end
        df = {1'b0, a, 32'h0} - {1'b0, bs, bx};
        if (df[96])
            return {64'h0, 32'h0, 16'h0, 1'b0, 1'b0, 1'b1};
        v = df[95:0];
        if (v == 0)
            return {64'h0, 32'h0, 16'h0, 1'b1, 1'b0, 1'b0};
        n = 0;
        while (!v[95]) begin
            v = v << 1;
            n++;
        end
        ex = int'($signed(ae)) - n;
        return {v[95:32], v[31:0], ex[15:0], 1'b0, ex < -32768, 1'b0};
    endfunction

    task automatic check(input string req, input logic [114:0] exp_v);
        logic [114:0] act;
        act = {res_sig, res_ext, res_exp, res_zero, res_uflow, res_err};
        n_checks++;
        if (!out_valid || act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: valid=%0b act=%h exp=%h", req, out_valid, act, exp_v);
        end
    endtask

    task automatic run_op(input string req, input logic [63:0] a, input logic [15:0] ae,
                          input logic [63:0] b, input logic [15:0] be);
        @(negedge clk);
        a_sig = a; a_exp = ae; b_sig = b; b_exp = be;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, model(a, ae, b, be));
    endtask

    task automatic t_reset;
        n_checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 reset: out_valid=%0b in_ready=%0b exp 0/1", out_valid, in_ready);
        end
    endtask

    task automatic t_near;
        run_op("R3 d0", 64'hC000_0000_0000_0001, 16'd5, 64'h8000_0000_0000_0003, 16'd5);
        run_op("R3 d1", 64'h8000_0000_0000_0000, 16'd3, 64'hFFFF_FFFF_0000_0001, 16'd2);
        run_op("R3 d31", 64'h9234_5678_9ABC_DEF0, 16'd100, 64'hFFFF_FFFF_FFFF_FFFF, 16'd69);
        run_op("R3 d32", 64'h8000_0000_0000_0000, 16'd40, 64'h8000_0000_1234_5678, 16'd8);
        check("R3 d32 literal", {64'hFFFF_FFFE_FFFF_FFFF, 32'hDB97_5310, 16'd39, 3'b000});
    endtask

    task automatic t_mid;
        run_op("R4 d33", 64'h8000_0000_0000_0000, 16'd33, 64'h8000_0003_0000_0001, 16'd0);
        run_op("R4 d33 nolow", 64'h8000_0000_0000_0000, 16'd33, 64'h8000_0003_0000_0000, 16'd0);
        run_op("R4 d63", 64'hA000_0000_0000_0000, -16'sd10, 64'hFFFF_FFFF_0000_0010, -16'sd73);
        run_op("R4 d64", 64'h8000_0000_0000_0001, 16'd64, 64'h8765_4321_0000_0001, 16'd0);
    endtask

    task automatic t_past;
        run_op("R5 d65 bit", 64'h8000_0000_0000_0000, 16'd65, 64'h8000_0001_0000_0000, 16'd0);
        run_op("R5 d65 low", 64'h8000_0000_0000_0000, 16'd65, 64'h8000_0000_0000_0100, 16'd0);
        run_op("R5 d65 none", 64'h8000_0000_0000_0000, 16'd65, 64'h8000_0000_0000_0000, 16'd0);
        run_op("R6 d66", 64'h8000_0000_0000_0000, 16'd66, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0);
        run_op("R6 d200", 64'hF000_0000_0000_0000, 16'd100, 64'h8000_0000_0000_0000, -16'sd100);
        check("R6 d200 literal", {64'hEFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 16'd100, 3'b000});
    endtask

    task automatic t_cancel;
        run_op("R9 shift64", 64'h8000_0000_0000_0000, 16'd70, 64'hFFFF_FFFF_FFFF_FFFF, 16'd69);
        check("R9 literal", {64'h8000_0000_0000_0000, 32'h0, 16'd6, 3'b000});
        run_op("R8 shift32", 64'h8000_0000_0000_0005, 16'd0, 64'h8000_0000_0000_0001, 16'd0);
        run_op("R10 zero", 64'hDEAD_BEEF_0123_4567, -16'sd7, 64'hDEAD_BEEF_0123_4567, -16'sd7);
        check("R10 literal", {64'h0, 32'h0, 16'h0, 3'b100});
    endtask

    task automatic t_errors;
        run_op("R2 a msb", 64'h4000_0000_0000_0000, 16'd4, 64'h8000_0000_0000_0000, 16'd1);
        check("R2 literal", {64'h0, 32'h0, 16'h0, 3'b001});
        run_op("R2 b msb", 64'h8000_0000_0000_0000, 16'd4, 64'h7FFF_0000_0000_0000, 16'd1);
        run_op("R2 neg gap", 64'hF000_0000_0000_0000, -16'sd2, 64'h8000_0000_0000_0000, 16'd3);
        run_op("R7 borrow", 64'h8000_0000_0000_0000, 16'd9, 64'h8000_0000_0000_0001, 16'd9);
        check("R7 literal", {64'h0, 32'h0, 16'h0, 3'b001});
    endtask

    task automatic t_uflow;
        run_op("R11 wrap", 64'hC000_0000_0000_0000, 16'h8000, 64'h8000_0000_0000_0000, 16'h8000);
        check("R11 literal", {64'h8000_0000_0000_0000, 32'h0, 16'h7FFF, 3'b010});
        run_op("R11 edge", 64'h8000_0000_0000_0000, 16'h8001, 64'h8000_0000_0000_0000, 16'h8000);
        check("R11 edge literal", {64'h8000_0000_0000_0000, 32'h0, 16'h8000, 3'b000});
    endtask

    task automatic t_backpressure;
        logic [114:0] first_v;
        logic [114:0] second_v;
        first_v  = model(64'hC000_0000_0000_0000, 16'd10, 64'h8000_0000_0000_0000, 16'd12);
        second_v = model(64'h9000_0000_0000_0000, 16'd3, 64'h8800_0000_0000_0000, 16'd3);
        @(negedge clk);
        out_ready = 1'b0;
        a_sig = 64'hC000_0000_0000_0000; a_exp = 16'd10;
        b_sig = 64'h8000_0000_0000_0000; b_exp = 16'd12;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        a_sig = 64'h9000_0000_0000_0000; a_exp = 16'd3;
        b_sig = 64'h8800_0000_0000_0000; b_exp = 16'd3;
        n_checks++;
        if (in_ready !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 blocked ready: act=%0b exp=0", in_ready);
        end
        repeat (3) @(negedge clk);
        check("R1 held", first_v);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 next", second_v);
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 drain: out_valid=%0b exp=0", out_valid);
        end
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 80; i++) begin
            logic [63:0] a;
            logic [63:0] b;
            logic [15:0] be;
            a  = {1'b1, 31'($urandom), 32'($urandom)};
            b  = {1'b1, 31'($urandom), 32'($urandom)};
            be = 16'(i - 20);
            run_op("R8 sweep", a, 16'(int'($signed(be)) + i), b, be);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_near();
        t_mid();
        t_past();
        t_cancel();
        t_errors();
        t_uflow();
        t_backpressure();
        t_sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule